// File: doc/BRIEF.md
# Pixel Arrival-Time and Charge Recorder

This block is the digital part of one pixel in a trigger-less hybrid pixel readout channel. It receives an asynchronous discriminator signal and a shared coarse time bus, and it runs on a single fast clock. A four-bit phase counter divides that clock by sixteen. Each wrap of the counter marks one coarse period. The phase value itself serves as the fine interpolation of the arrival time.

In timing mode, the rising edge of a hit latches the coarse bus value and the current phase. The block then counts coarse periods for as long as the discriminator stays high, which gives the time-over-threshold. In counting mode, the pixel adds up integrated time-over-threshold and counts hits across many events. All counters stop at their all-ones value instead of wrapping. A data-ready flag marks the pixels that hold data, so the readout only visits those pixels. In timing mode the flag rises when the hit ends. In counting mode it rises on a readout request. A read acknowledge lowers the flag and zeroes the counters.

Top module: `pix_hit_recorder`

## Requirements
- R1: After reset, `dataReady` is 0, every value output is 0, and the pixel is in timing mode.
- R2: Timing mode, idle pixel. `discIn` passes through a two-flop synchronizer. Let the input first be sampled high on fast edge e1. The capture happens at edge e1+2. `toaCoarse` takes the `coarseTime` value present before that capture edge. `toaFine` takes the phase value present before it. The phase value equals the number of fast edges since reset release, modulo 16.
- R3: A coarse tick is a fast edge whose index since reset release is a multiple of 16. In timing mode, `totCount` starts at 0 at capture. It adds 1 on each later tick at which the synchronized input is high, and it holds at all-ones.
- R4: Timing mode. Let the input first be sampled low on edge f1. `dataReady` rises after edge f1+2.
- R5: While `dataReady` is 1, further hits change none of the value outputs.
- R6: If `readAck` is sampled while `dataReady` is 1, then `dataReady` is 0 after that same edge and all value outputs are 0.
- R7: Counting mode. `evtCount` adds 1 for each synchronized rising edge and holds at all-ones.
- R8: Counting mode. `itotCount` adds 1 on each coarse tick at which the synchronized input is high and holds at all-ones.
- R9: In counting mode, `readReq` sampled high sets `dataReady` after that edge. In timing mode, `readReq` is ignored.
- R10: `countMode` (0 = timing, 1 = counting) is adopted only while the pixel is idle and the synchronized input is low. Adopting a new value clears all value outputs on that same edge. A change made while `dataReady` is 1 has no effect until after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (16 per coarse period) |
| rstN | input | 1 | Asynchronous active-low reset |
| discIn | input | 1 | Asynchronous discriminator output |
| coarseTime | input | COARSE_W (14) | Shared coarse time bus |
| countMode | input | 1 | 0 = timing mode, 1 = counting mode |
| readReq | input | 1 | Counting-mode request to present data |
| readAck | input | 1 | Readout acknowledge; clears the pixel |
| dataReady | output | 1 | Pixel holds data for readout |
| toaCoarse | output | COARSE_W (14) | Latched coarse arrival time |
| toaFine | output | FINE_W (4) | Latched fine phase |
| totCount | output | TOT_W (10) | Time-over-threshold in coarse periods |
| itotCount | output | ITOT_W (14) | Integrated time-over-threshold |
| evtCount | output | EVT_W (10) | Hit count |

## Verification
A phase counter that starts at the wrong value or drifts would show up immediately in `toaFine`. The same fault would also move the tick positions, so `totCount` would end up off by one on hits whose ends sit close to a tick. A wrong synchronizer depth would shift the fine value and the cycle in which `dataReady` rises by one step. A broken state register would show as hits that change data while the flag is already high, or as a flag that survives an acknowledge. The scoreboard checks all of these on the first readout that follows.

// File: rtl/pix_hit_pkg.sv
package pix_hit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_READY = 2'd2
  } pixState_t;

  typedef struct packed {
    logic capture;
    logic totInc;
    logic itotInc;
    logic evtInc;
    logic clearAll;
  } pixStrobe_t;

endpackage

// File: rtl/pix_hit_ctrl.sv
module pix_hit_ctrl
  import pix_hit_pkg::*;
#(
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              discIn,
  input  logic              countMode,
  input  logic              readReq,
  input  logic              readAck,
  output pixStrobe_t        strobe,
  output logic [FINE_W-1:0] phase,
  output logic              dataReady
);

  logic syncA, syncB, discPrev;
  logic riseDet, fallDet, coarseTick, modeSwitch;
  logic modeReg;
  pixState_t state, stateNext;

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      discPrev <= 1'b0;
    end else begin
      syncA    <= discIn;
      syncB    <= syncA;
      discPrev <= syncB;
    end
  end

  // fine phase counter: wraps once per coarse period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  assign coarseTick = &phase;
  assign riseDet    = syncB & ~discPrev;
  assign fallDet    = ~syncB & discPrev;
  assign modeSwitch = (state == ST_IDLE) && !syncB && (countMode != modeReg);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (modeSwitch) begin
      strobe.clearAll = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!modeReg) begin
            if (riseDet) begin
              strobe.capture = 1'b1;
              stateNext      = ST_BUSY;
            end
          end else begin
            strobe.evtInc  = riseDet;
            strobe.itotInc = coarseTick & syncB;
            if (readReq) stateNext = ST_READY;
          end
        end
        ST_BUSY: begin
          strobe.totInc = coarseTick & syncB;
          if (fallDet) stateNext = ST_READY;
        end
        ST_READY: begin
          if (readAck) begin
            strobe.clearAll = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (modeSwitch) modeReg <= countMode;
    end
  end

  assign dataReady = (state == ST_READY);

  // R5: data stays flagged until acknowledged
  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !readAck) |=> dataReady);

  // R6: acknowledge drops the flag on the next cycle
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && readAck) |=> !dataReady);

  // R10: mode register never moves while data is waiting
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (modeReg == $past(modeReg)));

endmodule

// File: rtl/pix_hit_dp.sv
module pix_hit_dp
  import pix_hit_pkg::*;
#(
  parameter int COARSE_W = 14,
  parameter int FINE_W   = 4,
  parameter int TOT_W    = 10,
  parameter int ITOT_W   = 14,
  parameter int EVT_W    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  pixStrobe_t          strobe,
  input  logic [COARSE_W-1:0] coarseTime,
  input  logic [FINE_W-1:0]   phase,
  output logic [COARSE_W-1:0] toaCoarse,
  output logic [FINE_W-1:0]   toaFine,
  output logic [TOT_W-1:0]    totCount,
  output logic [ITOT_W-1:0]   itotCount,
  output logic [EVT_W-1:0]    evtCount
);

  localparam logic [TOT_W-1:0]  TOT_MAX  = '1;
  localparam logic [ITOT_W-1:0] ITOT_MAX = '1;
  localparam logic [EVT_W-1:0]  EVT_MAX  = '1;

  // arrival-time registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toaCoarse <= '0;
      toaFine   <= '0;
    end else if (strobe.clearAll) begin
      toaCoarse <= '0;
      toaFine   <= '0;
    end else if (strobe.capture) begin
      toaCoarse <= coarseTime;
      toaFine   <= phase;
    end
  end

  // saturating time-over-threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   totCount <= '0;
    else if (strobe.clearAll || strobe.capture)  totCount <= '0;
    else if (strobe.totInc && totCount != TOT_MAX) totCount <= totCount + 1'b1;
  end

  // saturating integral time-over-threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  itotCount <= '0;
    else if (strobe.clearAll)   itotCount <= '0;
    else if (strobe.itotInc && itotCount != ITOT_MAX) itotCount <= itotCount + 1'b1;
  end

  // saturating event counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                evtCount <= '0;
    else if (strobe.clearAll) evtCount <= '0;
    else if (strobe.evtInc && evtCount != EVT_MAX) evtCount <= evtCount + 1'b1;
  end

  // R3: a full ToT counter never wraps back
  assert_tot_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (totCount == TOT_MAX && !strobe.clearAll && !strobe.capture) |=> (totCount == TOT_MAX));

  // R8: a full integral counter never wraps back
  assert_itot_sat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (itotCount == ITOT_MAX && !strobe.clearAll) |=> (itotCount == ITOT_MAX));

  // R7: event count only grows between clears
  assert_evt_mono_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearAll |=> (evtCount >= $past(evtCount)));

endmodule

// File: rtl/pix_hit_recorder.sv
module pix_hit_recorder
  import pix_hit_pkg::*;
#(
  parameter int COARSE_W = 14,
  parameter int FINE_W   = 4,
  parameter int TOT_W    = 10,
  parameter int ITOT_W   = 14,
  parameter int EVT_W    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                discIn,
  input  logic [COARSE_W-1:0] coarseTime,
  input  logic                countMode,
  input  logic                readReq,
  input  logic                readAck,
  output logic                dataReady,
  output logic [COARSE_W-1:0] toaCoarse,
  output logic [FINE_W-1:0]   toaFine,
  output logic [TOT_W-1:0]    totCount,
  output logic [ITOT_W-1:0]   itotCount,
  output logic [EVT_W-1:0]    evtCount
);

  pixStrobe_t        strobe;
  logic [FINE_W-1:0] phase;

  pix_hit_ctrl #(.FINE_W(FINE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .discIn    (discIn),
    .countMode (countMode),
    .readReq   (readReq),
    .readAck   (readAck),
    .strobe    (strobe),
    .phase     (phase),
    .dataReady (dataReady)
  );

  pix_hit_dp #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .TOT_W    (TOT_W),
    .ITOT_W   (ITOT_W),
    .EVT_W    (EVT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coarseTime (coarseTime),
    .phase      (phase),
    .toaCoarse  (toaCoarse),
    .toaFine    (toaFine),
    .totCount   (totCount),
    .itotCount  (itotCount),
    .evtCount   (evtCount)
  );

endmodule

// File: tb/pix_hit_recorder_test.sv
module pix_hit_recorder_test;

  localparam int CW = 14, FW = 4, TW = 10, IW = 8, EW = 4;
  localparam int TOT_MAX = (1 << TW) - 1;
  localparam int ITOT_MAX = (1 << IW) - 1;
  localparam int EVT_MAX = (1 << EW) - 1;

  logic clk = 1'b0, rstN = 1'b0, discIn = 1'b0, countMode = 1'b0;
  logic readReq = 1'b0, readAck = 1'b0;
  logic [CW-1:0] coarseTime = '0;
  logic dataReady;
  logic [CW-1:0] toaCoarse;
  logic [FW-1:0] toaFine;
  logic [TW-1:0] totCount;
  logic [IW-1:0] itotCount;
  logic [EW-1:0] evtCount;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    bit isCount;
    int coarse, fine, tot, itot, evt;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  pix_hit_recorder #(.COARSE_W(CW), .FINE_W(FW), .TOT_W(TW), .ITOT_W(IW), .EVT_W(EW)) uut (
    .clk(clk), .rstN(rstN), .discIn(discIn), .coarseTime(coarseTime),
    .countMode(countMode), .readReq(readReq), .readAck(readAck),
    .dataReady(dataReady), .toaCoarse(toaCoarse), .toaFine(toaFine),
    .totCount(totCount), .itotCount(itotCount), .evtCount(evtCount));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ticks(int lo, int hi);
    int n = 0;
    for (int e = lo; e <= hi; e++) if (e % 16 == 0) n++;
    return n;
  endfunction

  function automatic int minInt(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // monitor: compare each new readout against the scoreboard
  initial begin
    bit seen = 0;
    forever begin
      @(negedge clk);
      if (dataReady && !seen) begin
        expItem_t it;
        seen = 1;
        if (expQ.size() == 0) begin
          chk("R4 unexpected dataReady", 1, 0);
        end else begin
          it = expQ.pop_front();
          if (it.isCount) begin
            chk("R8 itotCount", int'(itotCount), it.itot);
            chk("R7 evtCount", int'(evtCount), it.evt);
          end else begin
            chk("R2 toaCoarse", int'(toaCoarse), it.coarse);
            chk("R2 toaFine", int'(toaFine), it.fine);
            chk("R3 totCount", int'(totCount), it.tot);
          end
        end
      end else if (!dataReady) seen = 0;
    end
  end

  // timing-mode hit with scoreboard push and R4 edge timing
  task automatic timingHit(int len, int coarse);
    int k, j;
    expItem_t it;
    coarseTime = CW'(coarse);
    @(negedge clk);
    k = cyc;
    discIn = 1'b1;
    repeat (len) @(negedge clk);
    j = cyc;
    discIn = 1'b0;
    it.isCount = 0;
    it.coarse = coarse;
    it.fine = (k + 2) % 16;
    it.tot = minInt(ticks(k + 4, j + 2), TOT_MAX);
    it.itot = 0;
    it.evt = 0;
    expQ.push_back(it);
    repeat (2) @(negedge clk);
    chk("R4 dataReady before f1+2", int'(dataReady), 0);
    @(negedge clk);
    chk("R4 dataReady after f1+2", int'(dataReady), 1);
  endtask

  task automatic ackRead();
    @(negedge clk);
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
    chk("R6 dataReady cleared", int'(dataReady), 0);
    chk("R6 values cleared", int'(toaCoarse) + int'(toaFine) + int'(totCount) +
        int'(itotCount) + int'(evtCount), 0);
  endtask

  task automatic countHit(int len, int gap, inout int expItot, inout int expEvt);
    int k, j;
    @(negedge clk);
    k = cyc;
    discIn = 1'b1;
    repeat (len) @(negedge clk);
    j = cyc;
    discIn = 1'b0;
    expItot += ticks(k + 3, j + 2);
    expEvt++;
    repeat (gap) @(negedge clk);
  endtask

  task automatic countRead(int expItot, int expEvt);
    expItem_t it;
    it.isCount = 1;
    it.coarse = 0; it.fine = 0; it.tot = 0;
    it.itot = minInt(expItot, ITOT_MAX);
    it.evt = minInt(expEvt, EVT_MAX);
    expQ.push_back(it);
    @(negedge clk);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    chk("R9 readReq sets dataReady", int'(dataReady), 1);
  endtask

  // watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int it, ev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dataReady", int'(dataReady), 0);
    chk("R1 values", int'(toaCoarse) + int'(toaFine) + int'(totCount) +
        int'(itotCount) + int'(evtCount), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 basic timing hits at different phases
    timingHit(20, 14'h1234);
    ackRead();
    repeat (5) @(negedge clk);
    timingHit(45, 14'h3FFF);
    ackRead();
    repeat (2) @(negedge clk);
    timingHit(3, 14'h0001);
    ackRead();

    // R9 readReq ignored in timing mode
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 readReq ignored in timing", int'(dataReady), 0);

    // R5 hits ignored while ready; R10 mode change deferred
    timingHit(30, 14'h0AAA);
    coarseTime = 14'h0005;
    discIn = 1'b1;
    repeat (10) @(negedge clk);
    discIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 coarse kept", int'(toaCoarse), 14'h0AAA);
    chk("R5 dataReady kept", int'(dataReady), 1);
    countMode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no clear while ready", int'(toaCoarse), 14'h0AAA);
    ackRead();
    repeat (3) @(negedge clk);

    // R7 R8 counting mode
    it = 0; ev = 0;
    countHit(20, 5, it, ev);
    countHit(7, 5, it, ev);
    countHit(33, 5, it, ev);
    chk("R7 evtCount live", int'(evtCount), 3);
    chk("R8 itotCount live", int'(itotCount), minInt(it, ITOT_MAX));
    countRead(it, ev);
    ackRead();

    // R7 event saturation
    it = 0; ev = 0;
    for (int h = 0; h < 17; h++) countHit(40, 4, it, ev);
    countRead(it, ev);
    ackRead();

    // R8 integral saturation
    it = 0; ev = 0;
    countHit(5000, 4, it, ev);
    countRead(it, ev);
    ackRead();

    // R10 mode change clears counters
    it = 0; ev = 0;
    countHit(25, 4, it, ev);
    countHit(25, 4, it, ev);
    chk("R7 two hits counted", int'(evtCount), 2);
    countMode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 evt cleared on switch", int'(evtCount), 0);
    chk("R10 itot cleared on switch", int'(itotCount), 0);
    timingHit(12, 14'h2222);
    ackRead();

    // R3 ToT saturation
    timingHit(16600, 14'h1111);
    ackRead();

    repeat (4) @(negedge clk);
    chk("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule